// File: doc/BRIEF.md
# Event-to-Counter Binding Table

This block keeps a small associative table that binds 20-bit event codes to performance counter indices. Each counter has a selector. A write to that selector either binds the code held in the selector's low 20 bits to that counter, or, when the whole written value is zero, removes every binding that targets the counter. Only a fixed set of five event codes can be bound, and each code has one slot. The first counter to claim a code keeps it until that counter is unbound.

Event pulses arrive tagged with their code. The lookup is combinational: in the same cycle it raises the increment strobe of the counter bound to that code. An unbound code produces no strobe. A query port reports whether a counter counts cycles or instructions. Counter 0 always counts cycles and counter 2 always counts instructions. Any other counter qualifies only through a binding to code 0x01 (cycles) or 0x02 (instructions). Counter storage and interrupt logic sit outside this block.

Top module: `evtmap_table`

## Requirements
- R1: After reset no binding exists. `inc_o` is zero for every event, `reject_o` is low, `is_cycle_o` is set only for query index 0, and `is_instr_o` is set only for query index 2.
- R2: The event code of a selector write is `sel_val_i[19:0]`. Bits above 19 do not affect which code is bound.
- R3: Only the codes 0x01, 0x02, 0x10019, 0x1001B and 0x10021 can be bound. A non-zero write carrying any other code makes no binding and is refused. This includes a non-zero value whose low 20 bits are zero.
- R4: A selector write to a counter index below 3, at or above NUM_CTRS, or whose bit in `avail_mask_i` is clear is refused and changes no binding. This holds for zero writes too. Index 0 therefore never becomes a target, and `inc_o[2:0]` stays zero.
- R5: A write of a code that is already bound is ignored without a refusal. Events for that code keep going to the first counter.
- R6: A zero write to an acceptable counter removes every binding that targets that counter and keeps bindings to other counters.
- R7: When `evt_valid_i` is high and `evt_id_i` is bound, `inc_o` has exactly the bound counter's bit set in the same cycle.
- R8: `inc_o` is all zero when `evt_valid_i` is low, or when the code is unbound or outside the accepted set.
- R9: `is_cycle_o` is high for query index 0 or for the counter bound to 0x01. `is_instr_o` is high for query index 2 or for the counter bound to 0x02. Both are combinational.
- R10: A selector write takes effect from the next cycle. A lookup in the write cycle sees the old table. A later non-zero write does not remove a counter's earlier binding, so one counter may hold several codes.
- R11: `reject_o` is high for exactly the one cycle after each refused write, and only after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| avail_mask_i | input | NUM_CTRS | Counters that may be bound |
| sel_we_i | input | 1 | Selector write strobe |
| sel_ctr_i | input | CTR_W | Counter index of the selector write |
| sel_val_i | input | SEL_W | Selector value written |
| evt_valid_i | input | 1 | Event pulse |
| evt_id_i | input | 20 | Code of the event pulse |
| inc_o | output | NUM_CTRS | Increment strobe, one bit per counter |
| query_ctr_i | input | CTR_W | Counter index for the kind query |
| is_cycle_o | output | 1 | Queried counter counts cycles |
| is_instr_o | output | 1 | Queried counter counts instructions |
| reject_o | output | 1 | Previous selector write was refused |

## Verification
Events are sent for every accepted code after binding, for codes never bound, and for a code outside the accepted set. This separates per-slot decoding from a plain valid gate. Selector writes cover every accepted code, codes carried with high flag bits, and a value that is non-zero but has zero in its low bits. Targets include low indices, out-of-range indices and masked counters, so range checks can be told apart from mask checks. Duplicate claims, unbinding a counter that holds two codes, and rebinding a freed code expose first-claim and by-counter removal. One write overlaps an event in the same cycle, which pins the one-cycle update latency.

// File: rtl/evtmap_pkg.sv
package evtmap_pkg;
  localparam int EVT_W      = 20;
  localparam int NUM_SLOTS  = 5;
  localparam int FIRST_PROG = 3;
  localparam int SLOT_CYC   = 0;
  localparam int SLOT_INS   = 1;

  function automatic logic [EVT_W-1:0] slot_code(input int s);
    case (s)
      0:       return 20'h00001;
      1:       return 20'h00002;
      2:       return 20'h10019;
      3:       return 20'h1001B;
      default: return 20'h10021;
    endcase
  endfunction
endpackage

// File: rtl/evtmap_code_dec.sv
module evtmap_code_dec
  import evtmap_pkg::*;
(
  input  logic [EVT_W-1:0]     id_i,
  output logic [NUM_SLOTS-1:0] hit_o
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
    assign hit_o[s] = (id_i == slot_code(s));
  end
endmodule

// File: rtl/evtmap_tgt_chk.sv
module evtmap_tgt_chk
  import evtmap_pkg::*;
#(
  parameter int NUM_CTRS = 32,
  parameter int CTR_W    = $clog2(NUM_CTRS) + 1
) (
  input  logic [CTR_W-1:0]    idx_i,
  input  logic [NUM_CTRS-1:0] avail_i,
  output logic                ok_o
);
  localparam int IW = $clog2(NUM_CTRS);

  logic in_rng;
  assign in_rng = (int'(idx_i) >= FIRST_PROG) && (int'(idx_i) < NUM_CTRS);
  assign ok_o   = in_rng && avail_i[idx_i[IW-1:0]];
endmodule

// File: rtl/evtmap_slot.sv
module evtmap_slot #(
  parameter int CTR_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [CTR_W-1:0] tgt_i,
  output logic             vld_o,
  output logic [CTR_W-1:0] tgt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      tgt_o <= '0;
    end else if (set_i) begin
      vld_o <= 1'b1;
      tgt_o <= tgt_i;
    end else if (clr_i) begin
      vld_o <= 1'b0;
    end
  end
endmodule

// File: rtl/evtmap_table.sv
module evtmap_table
  import evtmap_pkg::*;
#(
  parameter int NUM_CTRS = 32,
  parameter int CTR_W    = $clog2(NUM_CTRS) + 1,
  parameter int SEL_W    = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CTRS-1:0] avail_mask_i,
  input  logic                sel_we_i,
  input  logic [CTR_W-1:0]    sel_ctr_i,
  input  logic [SEL_W-1:0]    sel_val_i,
  input  logic                evt_valid_i,
  input  logic [EVT_W-1:0]    evt_id_i,
  output logic [NUM_CTRS-1:0] inc_o,
  input  logic [CTR_W-1:0]    query_ctr_i,
  output logic                is_cycle_o,
  output logic                is_instr_o,
  output logic                reject_o
);
  logic [NUM_SLOTS-1:0] vld, sel_hit, evt_hit;
  logic [CTR_W-1:0]     tgt [NUM_SLOTS];
  logic                 tgt_ok, sel_nz, rej_d;

  evtmap_code_dec i_sel_dec (.id_i(sel_val_i[EVT_W-1:0]), .hit_o(sel_hit));
  evtmap_code_dec i_evt_dec (.id_i(evt_id_i),             .hit_o(evt_hit));

  evtmap_tgt_chk #(.NUM_CTRS(NUM_CTRS), .CTR_W(CTR_W)) i_tgt_chk (
    .idx_i(sel_ctr_i), .avail_i(avail_mask_i), .ok_o(tgt_ok)
  );

  assign sel_nz = |sel_val_i;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic set_s, clr_s;
    // first claim wins: set only into a free slot
    assign set_s = sel_we_i && tgt_ok && sel_nz && sel_hit[s] && !vld[s];
    // zero write unbinds by target counter
    assign clr_s = sel_we_i && tgt_ok && !sel_nz && vld[s] && (tgt[s] == sel_ctr_i);
    evtmap_slot #(.CTR_W(CTR_W)) i_slot (
      .clk_i, .rst_ni, .set_i(set_s), .clr_i(clr_s), .tgt_i(sel_ctr_i),
      .vld_o(vld[s]), .tgt_o(tgt[s])
    );
  end

  always_comb begin
    inc_o = '0;
    for (int c = 0; c < NUM_CTRS; c++)
      for (int s = 0; s < NUM_SLOTS; s++)
        if (evt_valid_i && evt_hit[s] && vld[s] && (tgt[s] == CTR_W'(c)))
          inc_o[c] = 1'b1;
  end

  assign is_cycle_o = (query_ctr_i == CTR_W'(0)) ||
                      (vld[SLOT_CYC] && (tgt[SLOT_CYC] == query_ctr_i));
  assign is_instr_o = (query_ctr_i == CTR_W'(2)) ||
                      (vld[SLOT_INS] && (tgt[SLOT_INS] == query_ctr_i));

  assign rej_d = sel_we_i && (!tgt_ok || (sel_nz && !(|sel_hit)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reject_o <= 1'b0;
    else         reject_o <= rej_d;
  end
endmodule

// File: rtl/evtmap_table_chk.sv
module evtmap_table_chk
  import evtmap_pkg::*;
#(
  parameter int NUM_CTRS = 32,
  parameter int CTR_W    = $clog2(NUM_CTRS) + 1,
  parameter int SEL_W    = 64
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sel_we_i,
  input logic [CTR_W-1:0]    sel_ctr_i,
  input logic [SEL_W-1:0]    sel_val_i,
  input logic                evt_valid_i,
  input logic [NUM_CTRS-1:0] inc_o,
  input logic [CTR_W-1:0]    query_ctr_i,
  input logic                is_cycle_o,
  input logic                is_instr_o,
  input logic                reject_o
);
  a_r7_inc_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(inc_o));
  a_r8_no_inc_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_valid_i |-> (inc_o == '0));
  a_r4_low_ctr_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_o[2:0] == 3'b000);
  a_r4_low_tgt_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_we_i && (int'(sel_ctr_i) < FIRST_PROG)) |=> reject_o);
  a_r3_zero_id_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_we_i && (sel_val_i != '0) && (sel_val_i[EVT_W-1:0] == '0)) |=> reject_o);
  a_r11_reject_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> $past(sel_we_i));
  a_r11_reject_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reject_o && !sel_we_i) |=> !reject_o);
  a_r9_ctr0_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (query_ctr_i == '0) |-> is_cycle_o);
  a_r9_ctr2_instr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (query_ctr_i == CTR_W'(2)) |-> is_instr_o);
endmodule

bind evtmap_table evtmap_table_chk #(
  .NUM_CTRS(NUM_CTRS), .CTR_W(CTR_W), .SEL_W(SEL_W)
) i_evtmap_table_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_we_i(sel_we_i), .sel_ctr_i(sel_ctr_i),
  .sel_val_i(sel_val_i), .evt_valid_i(evt_valid_i), .inc_o(inc_o),
  .query_ctr_i(query_ctr_i), .is_cycle_o(is_cycle_o), .is_instr_o(is_instr_o),
  .reject_o(reject_o)
);

// File: tb/test_evtmap_table.sv
module test_evtmap_table;
  localparam int NUM_CTRS = 32;
  localparam int CTR_W    = 6;
  localparam int SEL_W    = 64;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic [NUM_CTRS-1:0] avail_mask_i = 32'h0007_FFF8; // counters 3..18
  logic                sel_we_i = 1'b0;
  logic [CTR_W-1:0]    sel_ctr_i = '0;
  logic [SEL_W-1:0]    sel_val_i = '0;
  logic                evt_valid_i = 1'b0;
  logic [19:0]         evt_id_i = '0;
  logic [NUM_CTRS-1:0] inc_o;
  logic [CTR_W-1:0]    query_ctr_i = '0;
  logic                is_cycle_o, is_instr_o, reject_o;

  int n_run = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  evtmap_table i_evtmap_table (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write a selector; afterwards reject_o shows the outcome
  task automatic wr(input int ctr, input logic [63:0] val, input bit exp_rej, input string req);
    @(negedge clk_i);
    sel_we_i = 1'b1; sel_ctr_i = CTR_W'(ctr); sel_val_i = val;
    @(negedge clk_i);
    sel_we_i = 1'b0; sel_val_i = '0;
    chk(req, 64'(reject_o), 64'(exp_rej));
  endtask

  task automatic ev(input logic [19:0] id, input logic [31:0] exp, input string req);
    @(negedge clk_i);
    evt_valid_i = 1'b1; evt_id_i = id;
    #1 chk(req, 64'(inc_o), 64'(exp));
    evt_valid_i = 1'b0;
  endtask

  task automatic qry(input int ctr, input bit cyc, input bit ins, input string req);
    query_ctr_i = CTR_W'(ctr);
    #1 chk(req, {62'd0, is_cycle_o, is_instr_o}, {62'd0, cyc, ins});
  endtask

  task automatic t_reset;
    chk("R1 reject", 64'(reject_o), 64'd0);
    ev(20'h00001, 32'h0, "R1 no binding cyc");
    ev(20'h10021, 32'h0, "R1 no binding 10021");
    qry(0, 1, 0, "R1 query0");
    qry(2, 0, 1, "R1 query2");
    qry(5, 0, 0, "R1 query5");
  endtask

  task automatic t_bad_target;
    wr(2,  64'h10021, 1, "R4 idx2");
    wr(40, 64'h10021, 1, "R4 idx40");
    wr(20, 64'h10021, 1, "R4 masked idx20");
    wr(1,  64'h0,     1, "R4 zero to idx1");
    ev(20'h10021, 32'h0, "R4 no binding made");
  endtask

  task automatic t_bind_basic;
    wr(5, 64'h1, 0, "R7 bind cyc");
    ev(20'h00001, 32'h1 << 5, "R7 cyc to 5");
    qry(5, 1, 0, "R9 ctr5 cycle");
    wr(6, 64'h8000_0000_0000_0002, 0, "R2 flag bits");
    ev(20'h00002, 32'h1 << 6, "R2 instr to 6");
    qry(6, 0, 1, "R9 ctr6 instr");
  endtask

  task automatic t_whitelist;
    wr(7, 64'h10019, 0, "R3 10019");
    wr(8, 64'h1001B, 0, "R3 1001B");
    wr(9, 64'h10021, 0, "R3 10021");
    ev(20'h10019, 32'h1 << 7, "R3 evt 10019");
    ev(20'h1001B, 32'h1 << 8, "R3 evt 1001B");
    ev(20'h10021, 32'h1 << 9, "R3 evt 10021");
    wr(10, 64'h10020, 1, "R3 bad code");
    @(negedge clk_i);
    chk("R11 one cycle", 64'(reject_o), 64'd0);
    ev(20'h10020, 32'h0, "R8 code outside set");
    wr(10, 64'hF000_0000_0000_0000, 1, "R3 zero low bits");
    ev(20'h00000, 32'h0, "R8 id zero");
  endtask

  task automatic t_first_wins;
    wr(11, 64'h1, 0, "R5 no reject on dup");
    ev(20'h00001, 32'h1 << 5, "R5 stays on 5");
    qry(11, 0, 0, "R5 ctr11 not cycle");
  endtask

  task automatic t_unbind;
    wr(5, 64'h0, 0, "R6 clear 5");
    ev(20'h00001, 32'h0, "R6 cyc unbound");
    ev(20'h00002, 32'h1 << 6, "R6 other kept");
    qry(5, 0, 0, "R6 ctr5 plain");
    wr(8, 64'h0, 0, "R6 clear 8");
    wr(11, 64'h1,     0, "R10 rebind cyc");
    wr(11, 64'h1001B, 0, "R10 second code");
    ev(20'h00001, 32'h1 << 11, "R10 multi cyc");
    ev(20'h1001B, 32'h1 << 11, "R10 multi 1001B");
    @(negedge clk_i);
    evt_valid_i = 1'b0; evt_id_i = 20'h1001B;
    #1 chk("R8 valid low", 64'(inc_o), 64'd0);
    wr(11, 64'h0, 0, "R6 clear 11");
    ev(20'h00001, 32'h0, "R6 both gone cyc");
    ev(20'h1001B, 32'h0, "R6 both gone 1001B");
  endtask

  task automatic t_timing;
    @(negedge clk_i);
    sel_we_i = 1'b1; sel_ctr_i = CTR_W'(12); sel_val_i = 64'h1001B;
    evt_valid_i = 1'b1; evt_id_i = 20'h1001B;
    #1 chk("R10 old table", 64'(inc_o), 64'd0);
    @(negedge clk_i);
    sel_we_i = 1'b0; sel_val_i = '0;
    #1 chk("R10 new table", 64'(inc_o), 64'(32'h1 << 12));
    evt_valid_i = 1'b0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_bad_target();
    t_bind_basic();
    t_whitelist();
    t_first_wins();
    t_unbind();
    t_timing();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule